// File: doc/BRIEF.md
# Link Power State Controller

This block is the device-side controller for the operating and power state of a host-to-modem link. After a power-on or hardware reset it holds the link in a reset state and keeps host register access closed. After a fixed settling delay it reports that it is ready for the host to initialise it. The host then requests the operational state by writing a requested-state code.

Once the link is operational, the device can drop into an idle suspend state without being asked. This happens when the physical interface shows no activity for a programmed number of cycles. After a further quiet period it moves to a deeper low-power state. Any activity wakes it back to the operational state. The host can also suspend the link explicitly and later resume it.

Every change of state raises a one-cycle request for a state-change event toward the event ring. A host command that is not legal in the current state is dropped and sets a sticky error flag.

Top module: `lpsc_top`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (RESET), `evt_req` is 0 and `err_flag` is 0. The state codes are RESET=0, READY=1, M0=2, M1=3, M2=4, M3=5, and `state_o` never shows a value above 5.
- R2: After `rst_n` rises, the state changes from RESET to READY on the RDY_DLY-th rising clock edge.
- R3: In READY, a write (`req_wr`=1) of code 2 moves the state to M0 at the next edge.
- R4: In M0, IDLE_M1 consecutive cycles with `phy_active` low move the state to M1. A cycle with `phy_active` high restarts that count. M1 is entered only from M0.
- R5: In M1, IDLE_M2 further consecutive inactive cycles move the state to M2.
- R6: `phy_active` high in M1 or M2 returns the state to M0 at the next edge.
- R7: `host_suspend` moves M0, M1 or M2 to M3, and M3 is entered only that way. `host_resume` moves M3 to M0. A legal host command takes precedence over activity and timer events in the same cycle.
- R8: A write of code 0 in any state other than RESET moves the state to RESET. The ready delay of R2 then restarts from that edge.
- R9: Any other host command is ignored and leaves the state unchanged. This covers a write of any other code in any state, a write of code 0 in RESET, a suspend in RESET, READY or M3, and a resume outside M3. Such a command sets `err_flag` at the next edge, and the flag stays set until reset.
- R10: `evt_req` is high for exactly the one cycle in which `state_o` first shows a new value, and it is low otherwise.
- R11: `host_acc_en` is low exactly while the state is RESET.
- R12: When several host inputs are high in the same cycle, only one command is taken, with priority `req_wr` > `host_suspend` > `host_resume`. The others are discarded and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on / hardware reset, asynchronous |
| req_wr | input | 1 | Host writes the requested-state register this cycle |
| req_state | input | 3 | Requested state code written by the host |
| phy_active | input | 1 | Physical interface activity indication |
| host_suspend | input | 1 | Host suspend request (one cycle) |
| host_resume | input | 1 | Host resume request (one cycle) |
| state_o | output | 3 | Current state code |
| host_acc_en | output | 1 | Host register access permitted (low in RESET) |
| evt_req | output | 1 | One-cycle state-change event request |
| err_flag | output | 1 | Sticky illegal-request flag |

## Verification
The bench sweeps every host command through every state from a fresh reset. It compares the next state, the event pulse, the access gate and the error flag against a legality table rebuilt in the bench, so a design that accepts a request it should refuse, such as M0 straight from RESET, changes state instead of flagging an error.

The timer boundaries are probed one cycle either side. An off-by-one dwell counter would leave M0, M1 or RESET one edge early or late, and a counter that ignores activity would still suspend after a broken idle period.

Simultaneous inputs are exercised to catch wrong priority. A suspend that loses to activity in M1 would land in M0. A reset write that loses to a suspend would land in M3. A discarded lower-priority command that wrongly raises the error flag is also caught.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_READY = 3'd1,
    ST_M0    = 3'd2,
    ST_M1    = 3'd3,
    ST_M2    = 3'd4,
    ST_M3    = 3'd5
  } lps_state_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_REQ  = 2'd1,
    CMD_SUSP = 2'd2,
    CMD_RES  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e  kind;
    logic [2:0] code;
  } host_cmd_t;

  // Legality of a host command in a given state.
  function automatic logic cmd_legal(lps_state_e s, host_cmd_t c);
    logic ok;
    ok = 1'b0;
    case (c.kind)
      CMD_REQ:  ok = ((c.code == ST_RESET) && (s != ST_RESET)) ||
                     ((c.code == ST_M0) && (s == ST_READY));
      CMD_SUSP: ok = (s == ST_M0) || (s == ST_M1) || (s == ST_M2);
      CMD_RES:  ok = (s == ST_M3);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Destination of a legal host command.
  function automatic lps_state_e cmd_target(lps_state_e s, host_cmd_t c);
    lps_state_e d;
    d = s;
    case (c.kind)
      CMD_REQ:  d = (c.code == ST_RESET) ? ST_RESET : ST_M0;
      CMD_SUSP: d = ST_M3;
      CMD_RES:  d = ST_M0;
      default:  d = s;
    endcase
    return d;
  endfunction

  // True on the last cycle of a dwell window of 'limit' cycles.
  function automatic logic dwell_last(int unsigned cnt, int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/lpsc_cmd_arb.sv
module lpsc_cmd_arb
  import lpsc_pkg::*;
(
  input  logic       req_wr,
  input  logic [2:0] req_state,
  input  logic       host_suspend,
  input  logic       host_resume,
  output host_cmd_t  cmd
);
  always_comb begin
    cmd = '{kind: CMD_NONE, code: 3'd0};
    if (req_wr)
      cmd = '{kind: CMD_REQ, code: req_state};
    else if (host_suspend)
      cmd = '{kind: CMD_SUSP, code: 3'd0};
    else if (host_resume)
      cmd = '{kind: CMD_RES, code: 3'd0};
  end
endmodule

// File: rtl/lpsc_cmd_check.sv
module lpsc_cmd_check
  import lpsc_pkg::*;
(
  input  lps_state_e state,
  input  host_cmd_t  cmd,
  output logic       cmd_ok,
  output logic       cmd_bad,
  output lps_state_e cmd_dest
);
  logic present;
  logic legal;

  assign present  = (cmd.kind != CMD_NONE);
  assign legal    = cmd_legal(state, cmd);
  assign cmd_ok   = present && legal;
  assign cmd_bad  = present && !legal;
  assign cmd_dest = cmd_target(state, cmd);
endmodule

// File: rtl/lpsc_dwell_timer.sv
module lpsc_dwell_timer
  import lpsc_pkg::*;
#(
  parameter int unsigned RDY_DLY = 16,
  parameter int unsigned IDLE_M1 = 1000,
  parameter int unsigned IDLE_M2 = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  lps_state_e state,
  input  logic       phy_active,
  input  logic       restart,
  output logic       rdy_done,
  output logic       idle_m1_hit,
  output logic       idle_m2_hit
);
  localparam int unsigned MAX_A   = (RDY_DLY > IDLE_M1) ? RDY_DLY : IDLE_M1;
  localparam int unsigned MAX_LIM = (MAX_A > IDLE_M2) ? MAX_A : IDLE_M2;
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             watch_act;
  int unsigned      cnt_i;

  assign watch_act = (state == ST_M0) || (state == ST_M1);
  assign cnt_i     = int'(cnt);

  assign rdy_done    = (state == ST_RESET) && dwell_last(cnt_i, RDY_DLY);
  assign idle_m1_hit = (state == ST_M0) && !phy_active && dwell_last(cnt_i, IDLE_M1);
  assign idle_m2_hit = (state == ST_M1) && !phy_active && dwell_last(cnt_i, IDLE_M2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart || (watch_act && phy_active))
      cnt <= '0;
    else if (cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpsc_state_core.sv
module lpsc_state_core
  import lpsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_ok,
  input  logic       cmd_bad,
  input  lps_state_e cmd_dest,
  input  logic       phy_active,
  input  logic       rdy_done,
  input  logic       idle_m1_hit,
  input  logic       idle_m2_hit,
  output lps_state_e state,
  output logic       change,
  output logic       evt_req,
  output logic       err_flag
);
  lps_state_e nxt;

  always_comb begin
    nxt = state;
    if (cmd_ok) begin
      nxt = cmd_dest;
    end else begin
      case (state)
        ST_RESET: if (rdy_done) nxt = ST_READY;
        ST_M0:    if (idle_m1_hit) nxt = ST_M1;
        ST_M1: begin
          if (phy_active)       nxt = ST_M0;
          else if (idle_m2_hit) nxt = ST_M2;
        end
        ST_M2:    if (phy_active) nxt = ST_M0;
        default:  nxt = state;
      endcase
    end
  end

  assign change = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RESET;
      evt_req  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      state    <= nxt;
      evt_req  <= change;
      err_flag <= err_flag | cmd_bad;
    end
  end
endmodule

// File: rtl/lpsc_top.sv
module lpsc_top
  import lpsc_pkg::*;
#(
  parameter int unsigned RDY_DLY = 16,
  parameter int unsigned IDLE_M1 = 1000,
  parameter int unsigned IDLE_M2 = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [2:0] req_state,
  input  logic       phy_active,
  input  logic       host_suspend,
  input  logic       host_resume,
  output logic [2:0] state_o,
  output logic       host_acc_en,
  output logic       evt_req,
  output logic       err_flag
);
  host_cmd_t  cmd_w;
  logic       cmd_ok_w;
  logic       cmd_bad_w;
  lps_state_e cmd_dest_w;
  lps_state_e state_w;
  logic       change_w;
  logic       rdy_done_w;
  logic       idle_m1_w;
  logic       idle_m2_w;

  lpsc_cmd_arb u_arb (
    .req_wr       (req_wr),
    .req_state    (req_state),
    .host_suspend (host_suspend),
    .host_resume  (host_resume),
    .cmd          (cmd_w)
  );

  lpsc_cmd_check u_chk (
    .state    (state_w),
    .cmd      (cmd_w),
    .cmd_ok   (cmd_ok_w),
    .cmd_bad  (cmd_bad_w),
    .cmd_dest (cmd_dest_w)
  );

  lpsc_dwell_timer #(
    .RDY_DLY (RDY_DLY),
    .IDLE_M1 (IDLE_M1),
    .IDLE_M2 (IDLE_M2)
  ) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_w),
    .phy_active  (phy_active),
    .restart     (change_w),
    .rdy_done    (rdy_done_w),
    .idle_m1_hit (idle_m1_w),
    .idle_m2_hit (idle_m2_w)
  );

  lpsc_state_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ok      (cmd_ok_w),
    .cmd_bad     (cmd_bad_w),
    .cmd_dest    (cmd_dest_w),
    .phy_active  (phy_active),
    .rdy_done    (rdy_done_w),
    .idle_m1_hit (idle_m1_w),
    .idle_m2_hit (idle_m2_w),
    .state       (state_w),
    .change      (change_w),
    .evt_req     (evt_req),
    .err_flag    (err_flag)
  );

  assign state_o     = state_w;
  assign host_acc_en = (state_w != ST_RESET);
endmodule

// File: rtl/lpsc_checker.sv
module lpsc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_o,
  input logic       host_acc_en,
  input logic       evt_req,
  input logic       err_flag,
  input logic       req_wr,
  input logic       host_suspend,
  input logic       cmd_bad
);
  // R1: state code within the defined encoding
  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);

  // R3: M0 reached from READY only through a register write
  assert_ready_to_m0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && $past(state_o) == 3'd1) |-> $past(req_wr));

  // R4: M1 entered only from M0
  assert_m1_from_m0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> $past(state_o) == 3'd2);

  // R7: M3 entered only on a host suspend
  assert_m3_by_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && $past(state_o) != 3'd5) |-> $past(host_suspend));

  // R9: illegal command raises the flag, and the flag is sticky
  assert_bad_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> err_flag);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R10: event pulse marks a change, silence marks stability
  assert_evt_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_req |-> (state_o != $past(state_o)));
  assert_no_evt_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_req |-> $stable(state_o));

  // R11: access gate opens when RESET is left
  assert_gate_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd0 && state_o != 3'd0) |-> $rose(host_acc_en));
endmodule

bind lpsc_top lpsc_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_o      (state_o),
  .host_acc_en  (host_acc_en),
  .evt_req      (evt_req),
  .err_flag     (err_flag),
  .req_wr       (req_wr),
  .host_suspend (host_suspend),
  .cmd_bad      (cmd_bad_w)
);

// File: tb/lpsc_top_tb.sv
`timescale 1ns/1ps
module lpsc_top_tb_top;
  localparam int RDY = 4;
  localparam int I1  = 5;
  localparam int I2  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_wr = 1'b0;
  logic [2:0] req_state = 3'd0;
  logic       phy_active = 1'b0;
  logic       host_suspend = 1'b0;
  logic       host_resume = 1'b0;
  logic [2:0] state_o;
  logic       host_acc_en;
  logic       evt_req;
  logic       err_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpsc_top #(.RDY_DLY(RDY), .IDLE_M1(I1), .IDLE_M2(I2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_state(req_state),
    .phy_active(phy_active), .host_suspend(host_suspend), .host_resume(host_resume),
    .state_o(state_o), .host_acc_en(host_acc_en), .evt_req(evt_req), .err_flag(err_flag)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; req_wr = 0; host_suspend = 0; host_resume = 0; phy_active = 0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int code);
    req_wr = 1'b1; req_state = 3'(code);
    step(1);
    req_wr = 1'b0;
  endtask

  task automatic goto_state(input int s);
    do_reset();
    if (s == 0) return;
    step(RDY);
    if (s == 1) return;
    wr(2);
    if (s == 2) return;
    if (s == 5) begin
      host_suspend = 1'b1; step(1); host_suspend = 1'b0;
      return;
    end
    step(I1);
    if (s == 3) return;
    step(I2);
  endtask

  // Expected legality and destination, from R3, R7, R8, R9
  function automatic bit exp_ok(int s, int k);
    if (k < 8) return (k == 0 && s != 0) || (k == 2 && s == 1);
    if (k == 8) return (s >= 2 && s <= 4);
    return (s == 5);
  endfunction

  function automatic int exp_dst(int s, int k);
    if (!exp_ok(s, k)) return s;
    if (k < 8) return k;
    if (k == 8) return 5;
    return 2;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 / R11 reset state
    step(2);
    chk(state_o, 0, "R1 state in reset");
    chk(evt_req, 0, "R1 evt in reset");
    chk(err_flag, 0, "R1 err in reset");
    chk(host_acc_en, 0, "R11 gate in reset");

    // R2 ready delay after power-on
    rst_n = 1'b1;
    step(RDY - 1);
    chk(state_o, 0, "R2 still RESET one edge early");
    step(1);
    chk(state_o, 1, "R2 READY on delay edge");
    chk(evt_req, 1, "R10 evt on READY entry");
    chk(host_acc_en, 1, "R11 gate open in READY");
    step(1);
    chk(evt_req, 0, "R10 evt single cycle");

    // R3 then R4 with activity restart
    wr(2);
    chk(state_o, 2, "R3 READY to M0");
    step(I1 - 1);
    phy_active = 1'b1; step(1); phy_active = 1'b0;
    step(I1 - 1);
    chk(state_o, 2, "R4 activity restarted idle count");
    step(1);
    chk(state_o, 3, "R4 M1 after full idle window");
    // R5 boundary
    step(I2 - 1);
    chk(state_o, 3, "R5 still M1 one edge early");
    step(1);
    chk(state_o, 4, "R5 M2 after second window");
    // R6 wake from M2
    phy_active = 1'b1; step(1);
    chk(state_o, 2, "R6 activity in M2 to M0");
    phy_active = 1'b0;
    // R6 wake from M1
    step(I1);
    chk(state_o, 3, "R6 back in M1");
    phy_active = 1'b1; step(1); phy_active = 1'b0;
    chk(state_o, 2, "R6 activity in M1 to M0");

    // R7 priority of suspend over activity in M1
    step(I1);
    host_suspend = 1'b1; phy_active = 1'b1; step(1);
    host_suspend = 1'b0; phy_active = 1'b0;
    chk(state_o, 5, "R7 suspend beats activity");
    step(I1 + I2);
    chk(state_o, 5, "R7 M3 holds without resume");
    host_resume = 1'b1; step(1); host_resume = 1'b0;
    chk(state_o, 2, "R7 resume to M0");
    chk(err_flag, 0, "R9 no error on legal sequence");

    // R12 write beats suspend, no error from discarded one
    req_wr = 1'b1; req_state = 3'd0; host_suspend = 1'b1; host_resume = 1'b1;
    step(1);
    req_wr = 1'b0; host_suspend = 1'b0; host_resume = 1'b0;
    chk(state_o, 0, "R12 write wins over suspend");
    chk(err_flag, 0, "R12 discarded command raises no error");
    // R8 restarted ready delay
    step(RDY - 1);
    chk(state_o, 0, "R8 delay restarted early edge");
    step(1);
    chk(state_o, 1, "R8 READY after restart delay");

    // R9 sticky across later legal transitions
    wr(5);
    chk(err_flag, 1, "R9 illegal write sets flag");
    chk(state_o, 1, "R9 illegal write leaves READY");
    wr(2);
    step(I1);
    chk(err_flag, 1, "R9 flag sticky");

    // Sweep: every command from every state (R3 R7 R8 R9 R10 R11)
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < 10; k++) begin
        int e;
        goto_state(s);
        chk(state_o, s, "R9 sweep setup state");
        e = exp_dst(s, k);
        if (k < 8) begin
          req_wr = 1'b1; req_state = 3'(k);
        end else if (k == 8) host_suspend = 1'b1;
        else host_resume = 1'b1;
        step(1);
        req_wr = 1'b0; host_suspend = 1'b0; host_resume = 1'b0;
        chk(state_o, e, $sformatf("R9 sweep s=%0d k=%0d state", s, k));
        chk(err_flag, exp_ok(s, k) ? 0 : 1, $sformatf("R9 sweep s=%0d k=%0d err", s, k));
        chk(evt_req, (e != s) ? 1 : 0, $sformatf("R10 sweep s=%0d k=%0d evt", s, k));
        chk(host_acc_en, (e != 0) ? 1 : 0, $sformatf("R11 sweep s=%0d k=%0d gate", s, k));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule